// File: doc/BRIEF.md
# Ping-Pong Buffer Bank Arbiter

This block shares a buffer memory split into a lower and an upper bank between a host bus port and an internal time-division engine. A registered bank bit names the bank the engine works in. Normally that bit flips on every frame-start strobe, so the engine and the host swap banks once per frame. A freeze control pins the bit to a configured value instead. Two per-bank force controls decide whether the host may always use a bank or only when the engine is in the other one.

Each host access is steered to one bank. In manual addressing the top host address bit picks the bank. In automatic addressing that bit is replaced by the bank not held by the engine. An access to a bank the host does not own is blocked: the write is dropped and the read returns a fixed poison word. For a short window after every bank change, memory is reserved for the engine. During that window a not-shared flag is high and all host accesses are blocked. When the window closes, a sticky interrupt is raised. It stays high until the host clears it.

Top module: `bank_arbiter`

## Requirements
- R1: After the active-low reset, engBank is 0, notShared is 0 and irq is 0.
- R2: With cfgFreeze low, a frameStart pulse sampled at a clock edge inverts engBank at that same edge.
- R3: With cfgFreeze high, engBank takes the value of cfgFrozenBank at the next edge, and frameStart has no effect on it.
- R4: Every change of engBank sets notShared high for exactly NS_CYCLES (default 4) cycles, starting with the edge of the change.
- R5: irq is set at the edge where notShared falls. It then holds until an edge with irqClr high clears it. If a set and a clear fall on the same edge, the set wins.
- R6: selLo (1 = lower bank on the host side) is 1 when cfgForceLo is 0 or engBank is 1. selHi (1 = upper bank on the host side) is 1 when cfgForceHi is 0 or engBank is 0.
- R7: With cfgAutoMap low, memAddr equals hostAddr. The address MSB picks the bank: 0 for lower, 1 for upper.
- R8: With cfgAutoMap high, the MSB of memAddr is the inverse of engBank, and the lower address bits pass through unchanged.
- R9: An access is blocked when the bank selected by the MSB of memAddr is not on the host side, or while notShared is high. A blocked access keeps memEn and memWe at 0. A blocked read returns 32'hDEADBEEF on hostRdata in the cycle after the read.
- R10: An access that is not blocked drives memEn high and sets memWe equal to hostWr. A read that is not blocked presents memRdata on hostRdata in the cycle after the read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameStart | input | 1 | Frame boundary strobe that flips the bank |
| cfgFreeze | input | 1 | Pin the bank assignment |
| cfgFrozenBank | input | 1 | Engine bank while frozen |
| cfgForceLo | input | 1 | 1: lower bank follows the bank bit; 0: host always |
| cfgForceHi | input | 1 | 1: upper bank follows the bank bit; 0: host always |
| cfgAutoMap | input | 1 | Replace the host address MSB with the host's bank |
| irqClr | input | 1 | Write-one-to-clear for irq |
| hostAddr | input | ADDR_W | Host address, MSB is the bank |
| hostRd | input | 1 | Host read strobe |
| hostWr | input | 1 | Host write strobe |
| hostWdata | input | DATA_W | Host write data |
| hostRdata | output | DATA_W | Host read data, one cycle after the read |
| memAddr | output | ADDR_W | Host-side memory address including bank bit |
| memEn | output | 1 | Host-side memory enable |
| memWe | output | 1 | Host-side memory write enable |
| memWdata | output | DATA_W | Host-side memory write data |
| memRdata | input | DATA_W | Memory read data, one cycle latency |
| selLo | output | 1 | Lower bank mux: 1 host, 0 engine |
| selHi | output | 1 | Upper bank mux: 1 host, 0 engine |
| engBank | output | 1 | Bank owned by the engine |
| notShared | output | 1 | Engine-exclusive window active |
| irq | output | 1 | Memory accessible again (sticky) |

## Verification
Two pairs of events can fall on the same edge. The first pair is the interrupt set at the end of a window and a host clear of that interrupt. The bench holds irqClr high across the exact edge where the window counter reaches zero, and requires irq to be high afterwards. The second pair is a bank change and a host access. The bench issues a read to a bank that the host has just gained, in the first cycle of the new window. It judges the outcome by memEn staying low and by the poison word returned a cycle later.

// File: rtl/bank_arb_pkg.sv
package bank_arb_pkg;

  // Strobes passed from the control to the datapath
  typedef struct packed {
    logic engBank;    // bank held by the engine
    logic notShared;  // engine-exclusive window
    logic hostLoOk;   // lower bank on host side
    logic hostHiOk;   // upper bank on host side
  } ctlStrobes_t;

endpackage

// File: rtl/bank_arb_ctrl.sv
module bank_arb_ctrl
  import bank_arb_pkg::*;
#(
  parameter int NS_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        frameStart,
  input  logic        cfgFreeze,
  input  logic        cfgFrozenBank,
  input  logic        cfgForceLo,
  input  logic        cfgForceHi,
  input  logic        irqClr,
  output ctlStrobes_t strobes,
  output logic        irq
);

  localparam int CNT_W = $clog2(NS_CYCLES + 1);
  localparam logic [CNT_W-1:0] WIN_LOAD = CNT_W'(NS_CYCLES);
  localparam logic [CNT_W-1:0] WIN_ONE  = CNT_W'(1);

  logic             bankQ;
  logic             nextBank;
  logic             bankChange;
  logic [CNT_W-1:0] winCnt;
  logic             windowEnd;
  logic             irqQ;

  // Next engine bank: frozen value wins over the frame toggle
  always_comb begin
    nextBank = bankQ;
    if (cfgFreeze)
      nextBank = cfgFrozenBank;
    else if (frameStart)
      nextBank = ~bankQ;
  end

  assign bankChange = (nextBank != bankQ);
  assign windowEnd  = (winCnt == WIN_ONE) && !bankChange;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bankQ  <= 1'b0;
      winCnt <= '0;
    end else begin
      bankQ <= nextBank;
      if (bankChange)
        winCnt <= WIN_LOAD;
      else if (winCnt != '0)
        winCnt <= winCnt - WIN_ONE;
    end
  end

  // Sticky interrupt, a set beats a clear on the same edge
  always_ff @(posedge clk) begin
    if (!rstN)
      irqQ <= 1'b0;
    else if (windowEnd)
      irqQ <= 1'b1;
    else if (irqClr)
      irqQ <= 1'b0;
  end

  assign irq               = irqQ;
  assign strobes.engBank   = bankQ;
  assign strobes.notShared = (winCnt != '0);
  assign strobes.hostLoOk  = !cfgForceLo || bankQ;
  assign strobes.hostHiOk  = !cfgForceHi || !bankQ;

endmodule

// File: rtl/bank_arb_datapath.sv
module bank_arb_datapath
  import bank_arb_pkg::*;
#(
  parameter int              ADDR_W   = 10,
  parameter int              DATA_W   = 32,
  parameter logic [DATA_W-1:0] BAD_WORD = DATA_W'(32'hDEAD_BEEF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobes_t       strobes,
  input  logic              cfgAutoMap,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  output logic              selLo,
  output logic              selHi
);

  localparam int MSB = ADDR_W - 1;

  logic effBank;
  logic bankOk;
  logic accessOk;
  logic badReadQ;

  // Bank bit: host supplied, or the bank opposite the engine
  assign effBank  = cfgAutoMap ? ~strobes.engBank : hostAddr[MSB];
  assign memAddr  = {effBank, hostAddr[MSB-1:0]};
  assign bankOk   = effBank ? strobes.hostHiOk : strobes.hostLoOk;
  assign accessOk = bankOk && !strobes.notShared;

  assign memEn    = (hostRd || hostWr) && accessOk;
  assign memWe    = hostWr && accessOk;
  assign memWdata = hostWdata;
  assign selLo    = strobes.hostLoOk;
  assign selHi    = strobes.hostHiOk;

  always_ff @(posedge clk) begin
    if (!rstN)
      badReadQ <= 1'b0;
    else
      badReadQ <= hostRd && !accessOk;
  end

  assign hostRdata = badReadQ ? BAD_WORD : memRdata;

endmodule

// File: rtl/bank_arbiter.sv
module bank_arbiter
  import bank_arb_pkg::*;
#(
  parameter int              ADDR_W    = 10,
  parameter int              DATA_W    = 32,
  parameter int              NS_CYCLES = 4,
  parameter logic [DATA_W-1:0] BAD_WORD  = DATA_W'(32'hDEAD_BEEF)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameStart,
  input  logic              cfgFreeze,
  input  logic              cfgFrozenBank,
  input  logic              cfgForceLo,
  input  logic              cfgForceHi,
  input  logic              cfgAutoMap,
  input  logic              irqClr,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostRd,
  input  logic              hostWr,
  input  logic [DATA_W-1:0] hostWdata,
  output logic [DATA_W-1:0] hostRdata,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memEn,
  output logic              memWe,
  output logic [DATA_W-1:0] memWdata,
  input  logic [DATA_W-1:0] memRdata,
  output logic              selLo,
  output logic              selHi,
  output logic              engBank,
  output logic              notShared,
  output logic              irq
);

  ctlStrobes_t strobes;

  bank_arb_ctrl #(.NS_CYCLES(NS_CYCLES)) u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .frameStart   (frameStart),
    .cfgFreeze    (cfgFreeze),
    .cfgFrozenBank(cfgFrozenBank),
    .cfgForceLo   (cfgForceLo),
    .cfgForceHi   (cfgForceHi),
    .irqClr       (irqClr),
    .strobes      (strobes),
    .irq          (irq)
  );

  bank_arb_datapath #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .BAD_WORD(BAD_WORD)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .cfgAutoMap(cfgAutoMap),
    .hostAddr  (hostAddr),
    .hostRd    (hostRd),
    .hostWr    (hostWr),
    .hostWdata (hostWdata),
    .memRdata  (memRdata),
    .hostRdata (hostRdata),
    .memAddr   (memAddr),
    .memEn     (memEn),
    .memWe     (memWe),
    .memWdata  (memWdata),
    .selLo     (selLo),
    .selHi     (selHi)
  );

  assign engBank   = strobes.engBank;
  assign notShared = strobes.notShared;

endmodule

// File: rtl/bank_arbiter_chk.sv
module bank_arbiter_chk #(
  parameter int                DATA_W   = 32,
  parameter logic [DATA_W-1:0] BAD_WORD = DATA_W'(32'hDEAD_BEEF)
) (
  input logic              clk,
  input logic              rstN,
  input logic              frameStart,
  input logic              cfgFreeze,
  input logic              cfgFrozenBank,
  input logic              irqClr,
  input logic              engBank,
  input logic              notShared,
  input logic              irq,
  input logic              hostRd,
  input logic              memEn,
  input logic              memWe,
  input logic [DATA_W-1:0] hostRdata
);

  // R2: a frame strobe flips the bank when not frozen
  a_r2_toggle: assert property (@(posedge clk) disable iff (!rstN)
    (frameStart && !cfgFreeze) |=> (engBank != $past(engBank)));

  // R3: frozen bank follows the configured value
  a_r3_frozen: assert property (@(posedge clk) disable iff (!rstN)
    cfgFreeze |=> (engBank == $past(cfgFrozenBank)));

  // R4: any bank change opens the window
  a_r4_window: assert property (@(posedge clk) disable iff (!rstN)
    (engBank != $past(engBank)) |-> notShared);

  // R5: window end raises irq
  a_r5_irq_set: assert property (@(posedge clk) disable iff (!rstN)
    $fell(notShared) |-> irq);

  // R5: irq holds without a clear
  a_r5_irq_hold: assert property (@(posedge clk) disable iff (!rstN)
    (irq && !irqClr) |=> irq);

  // R9: no memory write inside the window
  a_r9_no_write: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> !notShared);

  // R9: blocked read returns the poison word
  a_r9_bad_read: assert property (@(posedge clk) disable iff (!rstN)
    (hostRd && !memEn) |=> (hostRdata == BAD_WORD));

endmodule

bind bank_arbiter bank_arbiter_chk #(
  .DATA_W  (DATA_W),
  .BAD_WORD(BAD_WORD)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .frameStart   (frameStart),
  .cfgFreeze    (cfgFreeze),
  .cfgFrozenBank(cfgFrozenBank),
  .irqClr       (irqClr),
  .engBank      (engBank),
  .notShared    (notShared),
  .irq          (irq),
  .hostRd       (hostRd),
  .memEn        (memEn),
  .memWe        (memWe),
  .hostRdata    (hostRdata)
);

// File: tb/test_bank_arbiter.sv
module test_bank_arbiter;

  localparam int ADDR_W = 10;
  localparam int DATA_W = 32;
  localparam logic [31:0] POISON = 32'hDEAD_BEEF;
  localparam logic [31:0] MEMVAL = 32'h1234_5678;
  localparam logic [8:0]  LOWBITS = 9'h05A;

  // Vector fields: autoMap, forceLo, forceHi, addrMsb, wr, expEn, expMsb
  // All entries are applied with engBank = 0 and no window open.
  localparam int NVEC = 7;
  localparam logic [6:0] VEC [NVEC] = '{
    7'b0_0_0_0_0_1_0,  // manual, lower, host always -> ok
    7'b0_1_0_0_0_0_0,  // manual, lower forced, engine holds -> blocked
    7'b0_1_1_1_0_1_1,  // manual, upper forced, host side -> ok
    7'b1_1_1_0_0_1_1,  // auto, msb replaced by upper
    7'b1_0_0_0_1_1_1,  // auto write -> upper
    7'b0_1_0_0_1_0_0,  // manual write to engine bank -> dropped
    7'b0_0_1_1_1_1_1   // manual write upper forced, host side
  };

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              frameStart = 1'b0;
  logic              cfgFreeze = 1'b0;
  logic              cfgFrozenBank = 1'b0;
  logic              cfgForceLo = 1'b0;
  logic              cfgForceHi = 1'b0;
  logic              cfgAutoMap = 1'b0;
  logic              irqClr = 1'b0;
  logic [ADDR_W-1:0] hostAddr = '0;
  logic              hostRd = 1'b0;
  logic              hostWr = 1'b0;
  logic [DATA_W-1:0] hostWdata = 32'hCAFE_0001;
  logic [DATA_W-1:0] hostRdata;
  logic [ADDR_W-1:0] memAddr;
  logic              memEn;
  logic              memWe;
  logic [DATA_W-1:0] memWdata;
  logic [DATA_W-1:0] memRdata = MEMVAL;
  logic              selLo;
  logic              selHi;
  logic              engBank;
  logic              notShared;
  logic              irq;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bank_arbiter i_bank_arbiter (
    .clk(clk), .rstN(rstN), .frameStart(frameStart), .cfgFreeze(cfgFreeze),
    .cfgFrozenBank(cfgFrozenBank), .cfgForceLo(cfgForceLo),
    .cfgForceHi(cfgForceHi), .cfgAutoMap(cfgAutoMap), .irqClr(irqClr),
    .hostAddr(hostAddr), .hostRd(hostRd), .hostWr(hostWr),
    .hostWdata(hostWdata), .hostRdata(hostRdata), .memAddr(memAddr),
    .memEn(memEn), .memWe(memWe), .memWdata(memWdata), .memRdata(memRdata),
    .selLo(selLo), .selHi(selHi), .engBank(engBank), .notShared(notShared),
    .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] got,
                       input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;
    #1;
    check("R1 engBank reset", 32'(engBank), 32'd0);
    check("R1 notShared reset", 32'(notShared), 32'd0);
    check("R1 irq reset", 32'(irq), 32'd0);

    // Table of access vectors at engBank = 0
    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      cfgAutoMap = VEC[i][6];
      cfgForceLo = VEC[i][5];
      cfgForceHi = VEC[i][4];
      hostAddr   = {VEC[i][3], LOWBITS};
      hostWr     = VEC[i][2];
      hostRd     = !VEC[i][2];
      #1;
      check($sformatf("R9/R10 vec%0d memEn", i), 32'(memEn), 32'(VEC[i][1]));
      check($sformatf("R9/R10 vec%0d memWe", i), 32'(memWe),
            32'(VEC[i][1] && VEC[i][2]));
      check($sformatf("R7/R8 vec%0d memAddr", i), 32'(memAddr),
            32'({VEC[i][0], LOWBITS}));
      @(posedge clk); #1;
      if (!VEC[i][2])
        check($sformatf("R9/R10 vec%0d hostRdata", i), hostRdata,
              VEC[i][1] ? MEMVAL : POISON);
    end
    @(negedge clk);
    hostRd = 1'b0; hostWr = 1'b0; cfgAutoMap = 1'b0;
    cfgForceLo = 1'b1; cfgForceHi = 1'b1;
    #1;
    check("R6 selLo bank0", 32'(selLo), 32'd0);
    check("R6 selHi bank0", 32'(selHi), 32'd1);

    // Frame toggle, then a read in the new window
    @(negedge clk) frameStart = 1'b1;
    @(posedge clk); #1;
    check("R2 toggle", 32'(engBank), 32'd1);
    check("R4 window c1", 32'(notShared), 32'd1);
    check("R6 selLo bank1", 32'(selLo), 32'd1);
    check("R6 selHi bank1", 32'(selHi), 32'd0);
    @(negedge clk);
    frameStart = 1'b0; hostRd = 1'b1; hostAddr = {1'b0, LOWBITS};
    #1;
    check("R9 window blocks", 32'(memEn), 32'd0);
    @(posedge clk); #1;
    check("R9 window poison", hostRdata, POISON);
    check("R4 window c2", 32'(notShared), 32'd1);
    @(negedge clk) hostRd = 1'b0;
    @(posedge clk); #1;
    check("R4 window c3", 32'(notShared), 32'd1);
    @(posedge clk); #1;
    check("R4 window c4", 32'(notShared), 32'd1);
    check("R5 irq before end", 32'(irq), 32'd0);
    @(negedge clk) irqClr = 1'b1;   // clear on the edge that ends the window
    @(posedge clk); #1;
    check("R4 window closed", 32'(notShared), 32'd0);
    check("R5 set beats clear", 32'(irq), 32'd1);
    @(negedge clk) irqClr = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R5 irq held", 32'(irq), 32'd1);
    @(negedge clk) hostRd = 1'b1;
    #1;
    check("R10 lower after window", 32'(memEn), 32'd1);
    @(posedge clk); #1;
    check("R10 read data", hostRdata, MEMVAL);
    @(negedge clk);
    hostRd = 1'b0; irqClr = 1'b1;
    @(posedge clk); #1;
    check("R5 irq cleared", 32'(irq), 32'd0);
    @(negedge clk) irqClr = 1'b0;

    // Frozen bank
    @(negedge clk);
    cfgFreeze = 1'b1; cfgFrozenBank = 1'b0;
    @(posedge clk); #1;
    check("R3 frozen value", 32'(engBank), 32'd0);
    check("R4 frozen change window", 32'(notShared), 32'd1);
    @(negedge clk) frameStart = 1'b1;
    @(posedge clk); #1;
    check("R3 frame ignored", 32'(engBank), 32'd0);
    @(negedge clk) frameStart = 1'b0;
    repeat (4) @(posedge clk);
    #1;
    check("R4 frozen window closed", 32'(notShared), 32'd0);
    check("R5 irq after frozen window", 32'(irq), 32'd1);
    @(negedge clk);
    cfgAutoMap = 1'b1; hostWr = 1'b1; hostAddr = {1'b0, LOWBITS};
    #1;
    check("R8 auto msb", 32'(memAddr), 32'({1'b1, LOWBITS}));
    check("R10 auto write", 32'(memWe), 32'd1);
    check("R10 write data", memWdata, 32'hCAFE_0001);
    @(negedge clk) hostWr = 1'b0;

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule